// File: doc/BRIEF.md
# Condition Flag and Branch Decision Unit

This unit sits beside a processor's shared datapath bus. Whenever the control sequencer signals it, the unit samples the word on the bus and sorts it into one of three classes: negative, zero or positive. It keeps the class in three one-bit flag registers. The word may come from the ALU or from a memory or I/O read. Outside a load cycle the flags keep their value, so a later conditional branch can test the outcome of the last instruction that set them.

A second strobe, separate from the flag load, captures a branch decision into its own register. The decision combines the stored flags with a three-bit selection mask taken from the instruction (instruction bits 11, 10 and 9). The sequencer raises this strobe during decode, and a later step of the instruction uses the captured bit to choose the next program counter.

Top module: `cc_branch_unit`

## Requirements
- R1: A clock edge with `rst_n` low sets `flag_n`=0, `flag_z`=1, `flag_p`=0 and `branch_en`=0.
- R2: A clock edge with `cc_load`=1 and `bus_word[DATA_W-1]`=1 leaves only `flag_n` set.
- R3: A clock edge with `cc_load`=1 and `bus_word` all zero leaves only `flag_z` set.
- R4: A clock edge with `cc_load`=1 and a bus word that is neither negative nor zero leaves only `flag_p` set.
- R5: A clock edge with `cc_load`=0 leaves all three flags unchanged, whatever the bus carries.
- R6: Out of reset, exactly one of `flag_n`, `flag_z`, `flag_p` is 1 at all times.
- R7: A clock edge with `ben_load`=1 loads `branch_en` with (`ir_cond[2]` & N) | (`ir_cond[1]` & Z) | (`ir_cond[0]` & P). Here `ir_cond[2]` is instruction bit 11 and selects N, `ir_cond[1]` is bit 10 and selects Z, and `ir_cond[0]` is bit 9 and selects P.
- R8: A clock edge with `ben_load`=0 leaves `branch_en` unchanged.
- R9: When `cc_load` and `ben_load` are both high at the same edge, `branch_en` uses the flags held before that edge, not the newly loaded ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_word | input | DATA_W | Word currently driven on the datapath bus |
| cc_load | input | 1 | Load strobe for the three condition flags |
| ir_cond | input | 3 | Instruction bits 11:9, the n/z/p selection mask |
| ben_load | input | 1 | Load strobe for the branch decision |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_p | output | 1 | Stored positive flag |
| branch_en | output | 1 | Registered branch decision |

## Verification
The bench builds the unit with the default DATA_W of 16, so the sign bit is bit 15. With that width the words 0x0000, 0x8000, 0x7FFF and 0x0001 cover the zero case, the most negative word, the largest positive word and the smallest positive word. After each of these loads, all eight masks from 000 to 111 are applied, which sets every product term of the decision on its own and in combination. Further steps change the bus while the flag load is low, hold the decision strobe low while the mask changes, and raise both strobes in the same cycle to show that the decision uses the flags held before that edge.

// File: rtl/cc_pkg.sv
// Package: shared types and constants for the condition flag unit.
// Assumes the flag order n, z, p matches the instruction mask bits 2, 1, 0.
package cc_pkg;

    // Stored flags, packed so that bit 2 is n, bit 1 is z and bit 0 is p.
    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } nzp_t;

    localparam int NZP_W = 3;

    // Value the flags take on reset: zero class, a valid one-hot code.
    localparam nzp_t NZP_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

endpackage

// File: rtl/cc_sign_classify.sv
// Module: cc_sign_classify
// Sorts a bus word into negative, zero or positive, as a pure combinational
// function. Assumes two's-complement data with the sign in the top bit.
// The output is always one-hot.
module cc_sign_classify
    import cc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_in,
    output nzp_t              class_out
);

    localparam int SIGN_BIT = DATA_W - 1;

    logic is_neg;
    logic is_zero;

    // Detect the sign bit and an all-zero word.
    always_comb begin
        is_neg  = word_in[SIGN_BIT];
        is_zero = (word_in == '0);
    end

    // Build the one-hot class; a negative word can never be zero.
    always_comb begin
        class_out.n = is_neg;
        class_out.z = is_zero;
        class_out.p = ~is_neg & ~is_zero;
    end

endmodule

// File: rtl/cc_flag_reg.sv
// Module: cc_flag_reg
// Holds the three condition flags and loads them only on the load strobe.
// Assumes a synchronous active-low reset that forces the zero class.
module cc_flag_reg
    import cc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  nzp_t next_flags,
    output nzp_t flags
);

    // Flag storage: reset to the zero class, otherwise load or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= NZP_RESET;
        end else if (load) begin
            flags <= next_flags;
        end
    end

endmodule

// File: rtl/cc_branch_decide.sv
// Module: cc_branch_decide
// ANDs each stored flag with its mask bit, ORs the products, and registers
// the result on its own strobe. Assumes the mask bits are ordered like nzp_t.
module cc_branch_decide
    import cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NZP_W-1:0] mask,
    input  nzp_t             flags,
    output logic             decision
);

    logic [NZP_W-1:0] term;
    logic             any_term;

    // One product term per flag.
    generate
        for (genvar i = 0; i < NZP_W; i++) begin : g_term
            assign term[i] = mask[i] & flags[i];
        end
    endgenerate

    // Combine the product terms.
    always_comb begin
        any_term = |term;
    end

    // Decision storage: clear on reset, load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decision <= 1'b0;
        end else if (load) begin
            decision <= any_term;
        end
    end

endmodule

// File: rtl/cc_branch_unit.sv
// Module: cc_branch_unit (top)
// Condition flags taken from the datapath bus, plus a registered branch
// decision formed from those flags and the instruction's n/z/p mask.
// Assumes the sequencer drives both strobes for one cycle at a time. When
// both strobes rise together, the decision sees the flags from before the
// edge.
module cc_branch_unit
    import cc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_word,
    input  logic              cc_load,
    input  logic [2:0]        ir_cond,
    input  logic              ben_load,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_p,
    output logic              branch_en
);

    nzp_t bus_class;
    nzp_t held_flags;

    // Classify the bus word.
    cc_sign_classify #(.DATA_W(DATA_W)) u_classify (
        .word_in   (bus_word),
        .class_out (bus_class)
    );

    // Store the flags on command.
    cc_flag_reg u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cc_load),
        .next_flags (bus_class),
        .flags      (held_flags)
    );

    // Register the branch decision from the held flags.
    cc_branch_decide u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ben_load),
        .mask     (ir_cond),
        .flags    (held_flags),
        .decision (branch_en)
    );

    // Bring the flags out as separate pins.
    always_comb begin
        flag_n = held_flags.n;
        flag_z = held_flags.z;
        flag_p = held_flags.p;
    end

endmodule

// File: rtl/cc_branch_unit_chk.sv
// Module: cc_branch_unit_chk
// Property checker for cc_branch_unit, bound to every instance of it.
module cc_branch_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_word,
    input logic              cc_load,
    input logic [2:0]        ir_cond,
    input logic              ben_load,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_p,
    input logic              branch_en
);

    logic [2:0] fl;
    assign fl = {flag_n, flag_z, flag_p};

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (fl == 3'b010) && !branch_en);

    assert_neg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cc_load && bus_word[DATA_W-1] |=> fl == 3'b100);

    assert_zero_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cc_load && (bus_word == '0) |=> fl == 3'b010);

    assert_pos_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cc_load && !bus_word[DATA_W-1] && (bus_word != '0) |=> fl == 3'b001);

    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_load |=> $stable(fl));

    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(fl) == 1);

    assert_decision_R7_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ben_load |=> branch_en == $past(|(ir_cond & fl)));

    assert_decision_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ben_load |=> $stable(branch_en));

endmodule

bind cc_branch_unit cc_branch_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_word  (bus_word),
    .cc_load   (cc_load),
    .ir_cond   (ir_cond),
    .ben_load  (ben_load),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_p    (flag_p),
    .branch_en (branch_en)
);

// File: tb/sim_cc_branch_unit.sv
`timescale 1ns/1ps
module sim_cc_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_word = 16'h0;
    logic        cc_load = 1'b0;
    logic [2:0]  ir_cond = 3'b000;
    logic        ben_load = 1'b0;
    logic        flag_n, flag_z, flag_p, branch_en;

    int    checks = 0;
    int    errors = 0;
    bit    compare_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";
    string req_q = "R1";

    // Reference state
    bit m_n = 1'b0, m_z = 1'b1, m_p = 1'b0, m_b = 1'b0;

    cc_branch_unit #(.DATA_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .cc_load(cc_load),
        .ir_cond(ir_cond), .ben_load(ben_load), .flag_n(flag_n),
        .flag_z(flag_z), .flag_p(flag_p), .branch_en(branch_en)
    );

    always #2 clk = ~clk;

    // Behavioural reference model, updated on every rising edge.
    always @(posedge clk) begin : model
        bit nb;
        nb = (ir_cond[2] && m_n) || (ir_cond[1] && m_z) || (ir_cond[0] && m_p);
        if (!rst_n) begin
            m_n = 0; m_z = 1; m_p = 0; m_b = 0;
        end else begin
            if (ben_load) m_b = nb;
            if (cc_load) begin
                m_n = bus_word[15];
                m_z = (bus_word == 16'h0);
                m_p = !m_n && !m_z;
            end
        end
        req_q = cur_req;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (compare_on && !done) begin
            chk(req_q, "flag_n", int'(flag_n), int'(m_n));
            chk(req_q, "flag_z", int'(flag_z), int'(m_z));
            chk(req_q, "flag_p", int'(flag_p), int'(m_p));
            chk(req_q, "branch_en", int'(branch_en), int'(m_b));
            chk("R6", "flag count", int'(flag_n) + int'(flag_z) + int'(flag_p), 1);
        end
    end

    task automatic step(input logic [15:0] w, input logic cl, input logic [2:0] m,
                        input logic bl, input string req);
        @(negedge clk);
        bus_word = w; cc_load = cl; ir_cond = m; ben_load = bl; cur_req = req;
    endtask

    function automatic string cls_req(input logic [15:0] w);
        if (w[15]) return "R2";
        if (w == 16'h0) return "R3";
        return "R4";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    logic [15:0] vals [4] = '{16'h0000, 16'h8000, 16'h7FFF, 16'h0001};

    initial begin
        // R1: reset state, with strobes raised to show reset wins
        step(16'h8000, 1'b1, 3'b111, 1'b1, "R1");
        step(16'h8000, 1'b1, 3'b111, 1'b1, "R1");
        compare_on = 1'b1;
        step(16'h0000, 1'b0, 3'b000, 1'b0, "R1");
        rst_n = 1'b1;
        for (int v = 0; v < 4; v++) begin
            step(vals[v], 1'b1, 3'b000, 1'b0, cls_req(vals[v]));
            for (int m = 0; m < 8; m++) begin
                step(16'h0000, 1'b0, 3'(m), 1'b1, "R7");
                // R5/R8: bus and mask move, both strobes low
                step(vals[(v + 1) % 4] ^ 16'h5A5A, 1'b0, 3'(~m), 1'b0, "R8");
            end
        end
        // R5: several bus words without a load
        step(16'h8000, 1'b1, 3'b000, 1'b0, "R2");
        step(16'h0000, 1'b0, 3'b000, 1'b0, "R5");
        step(16'h0042, 1'b0, 3'b000, 1'b0, "R5");
        step(16'h0000, 1'b0, 3'b100, 1'b1, "R7");
        // R9: both strobes together; decision uses the old N flag
        step(16'h0000, 1'b1, 3'b100, 1'b1, "R9");
        step(16'h0000, 1'b0, 3'b000, 1'b0, "R9");
        step(16'h1234, 1'b1, 3'b010, 1'b1, "R9");
        step(16'h0000, 1'b0, 3'b000, 1'b0, "R9");
        step(16'h0000, 1'b0, 3'b001, 1'b1, "R7");
        step(16'h0000, 1'b0, 3'b000, 1'b0, "R8");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule